// File: doc/BRIEF.md
# Three-Wire Serial Register Master

This block runs single-register transactions against a peripheral that listens on three wires: a frame strobe, a serial clock and one data line whose driver can be released. A host presents an 8-bit register address, a 24-bit word to write and a read/write flag, then pulses start. The block stays busy while it shifts the frame out. It pulses done once the wires are back at rest. After a read it also presents the 24-bit word it collected.

A frame starts from a rest state in which all three wires sit high. The strobe drops to open the frame. Eight address bits follow, least significant first. The strobe stays low for the lower four of them and is raised before the upper four. Then come 24 data bits, also least significant first, with the strobe high. On a write the block drives these bits. On a read it releases the data pin, still pulses the clock, and picks up one bit after each rising clock edge. A low-then-high strobe pulse with clock and data high closes the frame.

Every bit is sent in two phases: clock low with the data value set, then clock high with the data held. The peripheral therefore samples on the rising clock edge. Each phase lasts a whole number of system clocks, set by a half-bit divider value that is captured when the frame is accepted.

Top module: `tw_reg_master`

## Requirements
- R1: Out of reset and whenever no frame is in progress, strobe, serial clock and data output are all 1, the data enable is 1, busy and done are 0, and the read word is 0 until a read completes.
- R2: A frame opens with the strobe falling while serial clock and data are both 1, before any serial clock edge.
- R3: The eight address bits go out least significant first, one per serial clock rising edge. The strobe is 0 at the rising edges of address bits 0 to 3 and 1 at those of address bits 4 to 7.
- R4: Data is set while the serial clock is low and does not change on the following rising edge.
- R5: On a write (read flag 0), the 24 data bits follow the address least significant first, with the strobe at 1 and the data enable at 1.
- R6: On a read (read flag 1), the data enable is 0 and the data output is 1 through all 24 data clock pulses. The bit present on the data input after rising data edge k becomes bit k of the read word, which is updated when the frame ends.
- R7: Each frame has exactly 32 serial clock rising edges. It closes with a second strobe fall, taken with serial clock and data at 1, followed by the strobe returning to 1.
- R8: Every serial clock low phase lasts exactly half_div+1 system clocks, where half_div is the divider value presented with start.
- R9: A start pulse that arrives while busy is ignored. The frame in flight keeps the address, data and direction that were latched when it was accepted, and no second frame follows.
- R10: Busy is 1 from the cycle after an accepted start until the frame ends. Done is a one-cycle pulse, given with busy at 0 once the wires are at rest.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse for one transaction |
| rd_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 8 | Register address |
| wdata_i | input | 24 | Word to write |
| half_div_i | input | 4 | Phase length in system clocks, minus one |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 24 | Word collected by the last read |
| strobe_o | output | 1 | Frame strobe wire |
| sclk_o | output | 1 | Serial clock wire |
| sdat_o | output | 1 | Data output value |
| sdat_oe_o | output | 1 | Data output enable, 0 = released |
| sdat_i | input | 1 | Data line input |

## Verification
The bench uses random addresses, write words, returned read words and divider values, interleaving reads and writes. A wrong bit order or a bit slip therefore shows up as a mismatched address or word, not as a coincidental match. The directed cases cover all-zero and all-one addresses and words, which separate stuck data from correct shifting. They also cover the smallest and the largest divider, which expose off-by-one phase lengths. A start raised mid-frame with inverted address, data and direction tells a design that latches its command apart from one that follows the live inputs or queues a second frame.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned ADDR_BITS    = 8;
  localparam int unsigned DATA_BITS    = 24;
  localparam int unsigned LOW_STB_BITS = 4;
  localparam int unsigned DIV_BITS     = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPEN,
    PH_ADDR,
    PH_DATA,
    PH_SHUT_LO,
    PH_SHUT_HI
  } phase_e;
endpackage

// File: rtl/tw_tick_gen.sv
module tw_tick_gen #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i || cnt_q == '0) cnt_d = div_i;
    else                       cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = run_i && (cnt_q == '0);
endmodule

// File: rtl/tw_frame_fsm.sv
module tw_frame_fsm
  import tw_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24,
  parameter int IDX_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             tick_i,
  output phase_e           phase_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             half_o,
  output logic             frame_end_o
);
  phase_e           ph_q, ph_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             half_q, half_d;

  always_comb begin
    ph_d        = ph_q;
    idx_d       = idx_q;
    half_d      = half_q;
    frame_end_o = 1'b0;
    case (ph_q)
      PH_IDLE: if (accept_i) begin
        ph_d   = PH_OPEN;
        idx_d  = '0;
        half_d = 1'b0;
      end
      PH_OPEN: if (tick_i) ph_d = PH_ADDR;
      PH_ADDR: if (tick_i) begin
        if (!half_q) half_d = 1'b1;
        else begin
          half_d = 1'b0;
          if (idx_q == IDX_W'(ADDR_W - 1)) begin
            ph_d  = PH_DATA;
            idx_d = '0;
          end else idx_d = idx_q + 1'b1;
        end
      end
      PH_DATA: if (tick_i) begin
        if (!half_q) half_d = 1'b1;
        else begin
          half_d = 1'b0;
          if (idx_q == IDX_W'(DATA_W - 1)) begin
            ph_d  = PH_SHUT_LO;
            idx_d = '0;
          end else idx_d = idx_q + 1'b1;
        end
      end
      PH_SHUT_LO: if (tick_i) ph_d = PH_SHUT_HI;
      PH_SHUT_HI: if (tick_i) begin
        ph_d        = PH_IDLE;
        frame_end_o = 1'b1;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      idx_q  <= '0;
      half_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      half_q <= half_d;
    end
  end

  assign phase_o = ph_q;
  assign idx_o   = idx_q;
  assign half_o  = half_q;
endmodule

// File: rtl/tw_bit_shifter.sv
module tw_bit_shifter #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 24,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              sample_i,
  input  logic              sdat_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              rd_o,
  output logic              addr_bit_o,
  output logic              data_bit_o,
  output logic [DATA_W-1:0] rx_o
);
  logic [ADDR_W-1:0] a_q, a_d;
  logic [DATA_W-1:0] w_q, w_d, rx_q, rx_d;
  logic              rd_q, rd_d;
  logic [ADDR_W-1:0] a_sel;
  logic [DATA_W-1:0] w_sel;

  always_comb begin
    a_d  = a_q;
    w_d  = w_q;
    rd_d = rd_q;
    rx_d = rx_q;
    if (load_i) begin
      a_d  = addr_i;
      w_d  = wdata_i;
      rd_d = rd_i;
    end
    if (sample_i) rx_d = {sdat_i, rx_q[DATA_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      w_q  <= '0;
      rd_q <= 1'b0;
      rx_q <= '0;
    end else begin
      a_q  <= a_d;
      w_q  <= w_d;
      rd_q <= rd_d;
      rx_q <= rx_d;
    end
  end

  assign a_sel      = a_q >> idx_i;
  assign w_sel      = w_q >> idx_i;
  assign addr_bit_o = a_sel[0];
  assign data_bit_o = w_sel[0];
  assign rd_o       = rd_q;
  assign rx_o       = rx_q;
endmodule

// File: rtl/tw_reg_master.sv
module tw_reg_master
  import tw_pkg::*;
#(
  parameter int ADDR_W   = tw_pkg::ADDR_BITS,
  parameter int DATA_W   = tw_pkg::DATA_BITS,
  parameter int LOW_BITS = tw_pkg::LOW_STB_BITS,
  parameter int DIV_W    = tw_pkg::DIV_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DIV_W-1:0]  half_div_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              strobe_o,
  output logic              sclk_o,
  output logic              sdat_o,
  output logic              sdat_oe_o,
  input  logic              sdat_i
);
  localparam int IDX_W = $clog2((ADDR_W > DATA_W ? ADDR_W : DATA_W) + 1);

  logic [1:0]        rst_sync_q;
  logic              core_rst_n;
  phase_e            phase;
  logic [IDX_W-1:0]  idx;
  logic              half, tick, frame_end, accept, busy, sample;
  logic              rd_lat, addr_bit, data_bit;
  logic [DATA_W-1:0] rx;
  logic [DIV_W-1:0]  div_q, div_d, div_sel;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              done_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  assign busy    = (phase != PH_IDLE);
  assign accept  = start_i && !busy;
  assign div_sel = busy ? div_q : half_div_i;
  assign sample  = tick && (phase == PH_DATA) && half && rd_lat;

  tw_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(core_rst_n), .run_i(busy), .div_i(div_sel), .tick_o(tick)
  );

  tw_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(core_rst_n), .accept_i(accept), .tick_i(tick),
    .phase_o(phase), .idx_o(idx), .half_o(half), .frame_end_o(frame_end)
  );

  tw_bit_shifter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
    .clk(clk), .rst_n(core_rst_n), .load_i(accept), .rd_i(rd_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .sample_i(sample), .sdat_i(sdat_i),
    .idx_i(idx), .rd_o(rd_lat), .addr_bit_o(addr_bit), .data_bit_o(data_bit),
    .rx_o(rx)
  );

  always_comb begin
    div_d   = accept ? half_div_i : div_q;
    rdata_d = (frame_end && rd_lat) ? rx : rdata_q;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      div_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      div_q   <= div_d;
      rdata_q <= rdata_d;
      done_q  <= frame_end;
    end
  end

  // wire levels decoded from the sequencer state
  always_comb begin
    strobe_o  = 1'b1;
    sclk_o    = 1'b1;
    sdat_o    = 1'b1;
    sdat_oe_o = 1'b1;
    case (phase)
      PH_OPEN, PH_SHUT_LO: strobe_o = 1'b0;
      PH_ADDR: begin
        strobe_o = (idx >= IDX_W'(LOW_BITS));
        sclk_o   = half;
        sdat_o   = addr_bit;
      end
      PH_DATA: begin
        sclk_o    = half;
        sdat_o    = rd_lat ? 1'b1 : data_bit;
        sdat_oe_o = !rd_lat;
      end
      default: ;
    endcase
  end

  assign busy_o  = busy;
  assign done_o  = done_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/tw_reg_master_chk.sv
module tw_reg_master_chk #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 24,
  parameter int LOW_BITS = 4,
  parameter int DIV_W    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              rd_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DIV_W-1:0]  half_div_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rdata_o,
  input logic              strobe_o,
  input logic              sclk_o,
  input logic              sdat_o,
  input logic              sdat_oe_o,
  input logic              sdat_i
);
  // R1
  rest_wires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (strobe_o && sclk_o && sdat_o && sdat_oe_o));

  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> $stable(sdat_o));

  // R2
  strobe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_o) |-> (sclk_o && sdat_o && sdat_oe_o));

  // R6
  released_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sdat_oe_o |-> (sdat_o && busy_o && strobe_o));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> busy_o || done_o);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10
  done_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
endmodule

bind tw_reg_master tw_reg_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOW_BITS(LOW_BITS), .DIV_W(DIV_W)
) u_chk (.*);

// File: tb/sim_tw_reg_master.sv
`timescale 1ns/1ps
module sim_tw_reg_master;
  localparam int AW = 8;
  localparam int DW = 24;
  localparam int LB = 4;
  localparam int VW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          rd_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [VW-1:0] half_div_i = '0;
  logic          busy_o, done_o, strobe_o, sclk_o, sdat_o, sdat_oe_o;
  logic [DW-1:0] rdata_o;
  logic          sdat_i;

  int checks = 0;
  int errors = 0;

  // expected command of the frame in flight, and the peripheral's reply
  logic          cur_rd;
  logic [AW-1:0] cur_addr;
  logic [DW-1:0] cur_wdata;
  logic [VW-1:0] cur_div;
  logic [DW-1:0] reply;

  // monitor state
  int            edges, falls, lowcnt, done_cnt;
  int            stb_err, hold_err, oe_err, low_err, open_err;
  logic [AW-1:0] cap_a;
  logic [DW-1:0] cap_d;
  logic          prev_stb, prev_sclk, prev_dat;

  always #2 clk = ~clk;

  tw_reg_master u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .half_div_i(half_div_i), .busy_o(busy_o), .done_o(done_o),
    .rdata_o(rdata_o), .strobe_o(strobe_o), .sclk_o(sclk_o), .sdat_o(sdat_o),
    .sdat_oe_o(sdat_oe_o), .sdat_i(sdat_i)
  );

  function automatic logic exp_strobe(input int k);
    return (k >= LB);
  endfunction

  function automatic int exp_low(input logic [VW-1:0] d);
    return int'(d) + 1;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus observer and peripheral model, sampled on the falling clock edge
  always @(negedge clk) begin
    if (!rst_n) begin
      sdat_i    = 1'b1;
      prev_stb  = 1'b1;
      prev_sclk = 1'b1;
      prev_dat  = 1'b1;
    end else begin
      if (start_i && !busy_o) begin
        edges = 0; falls = 0; lowcnt = 0; done_cnt = 0;
        stb_err = 0; hold_err = 0; oe_err = 0; low_err = 0; open_err = 0;
        cap_a = '0; cap_d = '0;
      end else begin
        if (prev_stb && !strobe_o) begin
          if (!(sclk_o && sdat_o && sdat_oe_o)) open_err++;
          if (falls == 0 && edges != 0) open_err++;
          if (falls == 1 && edges != AW + DW) open_err++;
          falls++;
        end
        if (!prev_sclk && sclk_o) begin
          if (lowcnt != exp_low(cur_div)) low_err++;
          if (sdat_o != prev_dat) hold_err++;
          if (edges < AW) begin
            cap_a[edges] = sdat_o;
            if (strobe_o != exp_strobe(edges)) stb_err++;
          end else if (edges < AW + DW) begin
            cap_d[edges-AW] = sdat_o;
            if (strobe_o != 1'b1) stb_err++;
            if (sdat_oe_o != !cur_rd) oe_err++;
            if (cur_rd && sdat_o != 1'b1) oe_err++;
          end
          edges++;
        end
        if (!sclk_o) lowcnt++;
        else         lowcnt = 0;
        if (prev_sclk && !sclk_o && cur_rd && edges >= AW && edges < AW + DW)
          sdat_i = reply[edges-AW];
        if (done_o) done_cnt++;
      end
      prev_stb  = strobe_o;
      prev_sclk = sclk_o;
      prev_dat  = sdat_o;
    end
  end

  task automatic check_rest(input string tag);
    chk(strobe_o && sclk_o && sdat_o && sdat_oe_o, {tag, " wires at rest"},
        {strobe_o, sclk_o, sdat_o, sdat_oe_o}, 4'hF);
    chk(!busy_o && !done_o, {tag, " busy/done low"}, {busy_o, done_o}, 0);
  endtask

  task automatic do_txn(input logic rd, input logic [AW-1:0] a,
                        input logic [DW-1:0] w, input logic [VW-1:0] d,
                        input logic [DW-1:0] rep, input bit poke);
    logic [DW-1:0] prev_rdata;
    bit got;
    prev_rdata = rdata_o;
    cur_rd = rd; cur_addr = a; cur_wdata = w; cur_div = d; reply = rep;
    @(posedge clk); #1;
    rd_i = rd; addr_i = a; wdata_i = w; half_div_i = d; start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    // R10: busy from the cycle after the accepted start
    chk(busy_o == 1'b1, "R10 busy after start", busy_o, 1);
    if (poke) begin
      repeat (6) @(posedge clk);
      #1;
      rd_i = ~rd; addr_i = ~a; wdata_i = ~w; half_div_i = ~d; start_i = 1'b1;
      @(posedge clk); #1;
      start_i = 1'b0;
    end
    got = 0;
    for (int n = 0; n < 20000; n++) begin
      @(negedge clk);
      if (done_o) begin got = 1; break; end
    end
    #1;
    chk(got, "R10 done seen", got, 1);
    chk(!busy_o, "R10 busy low with done", busy_o, 0);
    chk(open_err == 0, "R2 frame open", open_err, 0);
    chk(cap_a == cur_addr, "R3 address bits", cap_a, cur_addr);
    chk(stb_err == 0, "R3 strobe level per bit", stb_err, 0);
    chk(hold_err == 0, "R4 data held at rise", hold_err, 0);
    if (!rd) begin
      chk(cap_d == cur_wdata, "R5 write word", cap_d, cur_wdata);
      chk(oe_err == 0, "R5 write enable", oe_err, 0);
    end else begin
      chk(rdata_o == reply, "R6 read word", rdata_o, reply);
      chk(oe_err == 0, "R6 data released", oe_err, 0);
    end
    if (!rd) chk(rdata_o == prev_rdata, "R6 read word kept on write", rdata_o, prev_rdata);
    chk(edges == AW + DW, "R7 clock count", edges, AW + DW);
    chk(falls == 2, "R7 strobe falls", falls, 2);
    chk(low_err == 0, "R8 low phase length", low_err, 0);
    @(negedge clk); #1;
    chk(!done_o, "R10 done one cycle", done_o, 0);
    check_rest("R1 after frame");
    repeat (10) @(negedge clk);
    #1;
    chk(done_cnt == 1, poke ? "R9 single done" : "R10 single done", done_cnt, 1);
    chk(!busy_o && sclk_o, "R9 no queued frame", {busy_o, sclk_o}, 1);
  endtask

  initial begin
    #(4ns * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240917));
    cur_rd = 1'b0; cur_div = '0; reply = '0; cur_addr = '0; cur_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1 reset state
    check_rest("R1 reset");
    chk(rdata_o == '0, "R1 read word reset", rdata_o, 0);

    // directed corners
    do_txn(1'b0, 8'h00, 24'h000000, 4'd0, 24'h0, 1'b0);
    do_txn(1'b0, 8'hFF, 24'hFFFFFF, 4'd15, 24'h0, 1'b0);
    do_txn(1'b1, 8'hA5, 24'h0, 4'd0, 24'hFFFFFF, 1'b0);
    do_txn(1'b1, 8'h0F, 24'h0, 4'd7, 24'h000001, 1'b0);
    do_txn(1'b0, 8'h3C, 24'h800001, 4'd1, 24'h0, 1'b0);
    // R9 start during busy, write and read
    do_txn(1'b0, 8'h5A, 24'h123456, 4'd2, 24'h0, 1'b1);
    do_txn(1'b1, 8'hC3, 24'h0, 4'd1, 24'hABCDEF, 1'b1);

    // random mix
    for (int i = 0; i < 24; i++) begin
      do_txn(1'($urandom), 8'($urandom), 24'($urandom), 4'($urandom_range(0, 3)),
             24'($urandom), (i % 6) == 5);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule